// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves destination addresses to next-hop identifiers by longest-prefix match. It uses two directly indexed tables and no trie walk. The upper bits of each address select an entry in a first table. That entry either names the next hop outright or points into a second table. In the pointer case, the low address bits select the final word within the second table. Prefixes no longer than the first-table index are served by the first table alone. Longer prefixes are expanded into blocks of the second table.

Lookups stream in at up to one address per clock. Every lookup leaves the block exactly two cycles after it enters, whichever table ends up providing the answer, and results leave in arrival order. A simple load port lets software fill either table one word per cycle. Computing routes and expanding prefixes into table words are done outside the block. A next hop of zero means "no route", and the block reports it with a miss flag.

Top module: `route_lookup`

## Requirements
- R1: During and after reset, `res_valid` is 0 until a lookup accepted after reset comes out. A reset applied while lookups are in flight discards them.
- R2: A lookup presented with `lk_valid`=1 at a rising edge appears on `res_valid` after exactly the second following rising edge. One lookup is accepted per cycle, and results come out in the order the lookups were accepted.
- R3: The first-table index is `lk_addr[ADDR_W-1:LOW_W]`. A first-table word with bit 15 = 1 is a leaf. For a leaf, `res_hop` equals word bits 14:0 and the low address bits have no effect.
- R4: A first-table word with bit 15 = 0 and a nonzero bits 14:0 is a pointer. The block reads the second table at index (bits [L2_AW-1:0] of the word + `lk_addr[LOW_W-1:0]`) mod 2^L2_AW, and `res_hop` equals bits 14:0 of that second-table word.
- R5: A first-table word of 0x0000 is empty. A lookup that lands on it returns a miss, whatever the second table holds.
- R6: When the resolved next hop is zero, `res_miss`=1 and `res_hop`=0. When it is nonzero, `res_miss`=0. This holds for next hops taken from either table.
- R7: With `ld_en`=1, `ld_level`=0 writes `ld_data` into first-table word `ld_addr[L1_IDX_W-1:0]`. `ld_level`=1 writes `ld_data[14:0]` into second-table word `ld_addr[L2_AW-1:0]`. Later lookups see the new value.
- R8: A lookup accepted in the same cycle as a load into the first-table word it reads returns the old word. The next lookup to that entry returns the new word.
- R9: While `res_valid`=0, `res_hop` and `res_miss` are both 0.
- R10: The second-table index wraps modulo 2^L2_AW when pointer plus low bits overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | ADDR_W (20) | Destination address to resolve |
| ld_en | input | 1 | Table load strobe |
| ld_level | input | 1 | 0 selects first table, 1 selects second table |
| ld_addr | input | LD_AW (12) | Word index for the load |
| ld_data | input | 16 | Word to load |
| res_valid | output | 1 | Result present |
| res_hop | output | 15 | Resolved next hop, 0 on miss |
| res_miss | output | 1 | No route for the address |

## Verification
The bench streams back-to-back lookups that mix leaf entries, pointer entries, empty entries, a zero next hop in each table, a pointer whose index overflows, and the highest first-table index. A design that added a cycle for the second-table path would misorder or misalign these results. A design that handled empty words as pointers to block zero would return the decoy word stored there instead of a miss, and a design that did not wrap the index would read the wrong word. A load that collides with a lookup of the same entry catches a design that forwards new data too early. Extra checks cover a single isolated lookup, updates to the second table, and a reset taken with results in flight, which catch latency drift and stale results.

// File: rtl/rlk_pkg.sv
package rlk_pkg;

    localparam int ENTRY_W = 16;
    localparam int HOP_W   = ENTRY_W - 1;

    typedef logic [HOP_W-1:0] hop_t;

    typedef struct packed {
        logic       leaf;
        logic [HOP_W-1:0] val;
    } l1_entry_t;

    typedef enum logic {
        LVL_FIRST  = 1'b0,
        LVL_SECOND = 1'b1
    } level_e;

    function automatic logic entry_is_empty(l1_entry_t e);
        return (!e.leaf) && (e.val == '0);
    endfunction

endpackage

// File: rtl/rlk_table.sv
module rlk_table #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Read returns the word held before any same-cycle write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rlk_l2_index.sv
module rlk_l2_index #(
    parameter int LOW_W = 8,
    parameter int L2_AW = 11
) (
    input  logic [L2_AW-1:0] base,
    input  logic [LOW_W-1:0] low,
    output logic [L2_AW-1:0] idx
);
    generate
        if (LOW_W >= L2_AW) begin : g_trunc
            assign idx = base + low[L2_AW-1:0];
        end else begin : g_extend
            assign idx = base + {{(L2_AW-LOW_W){1'b0}}, low};
        end
    endgenerate
endmodule

// File: rtl/rlk_resolve.sv
module rlk_resolve
    import rlk_pkg::*;
(
    input  logic      valid,
    input  l1_entry_t ent,
    input  hop_t      l2_word,
    output logic      out_valid,
    output hop_t      out_hop,
    output logic      out_miss
);
    hop_t picked;

    always_comb begin
        if (entry_is_empty(ent)) begin
            picked = '0;
        end else if (ent.leaf) begin
            picked = ent.val;
        end else begin
            picked = l2_word;
        end

        out_valid = valid;
        out_hop   = valid ? picked : '0;
        out_miss  = valid && (picked == '0);
    end
endmodule

// File: rtl/route_lookup.sv
module route_lookup
    import rlk_pkg::*;
#(
    parameter int L1_IDX_W = 12,
    parameter int LOW_W    = 8,
    parameter int L2_AW    = 11,
    localparam int ADDR_W  = L1_IDX_W + LOW_W,
    localparam int LD_AW   = (L1_IDX_W > L2_AW) ? L1_IDX_W : L2_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              ld_en,
    input  logic              ld_level,
    input  logic [LD_AW-1:0]  ld_addr,
    input  logic [ENTRY_W-1:0] ld_data,
    output logic              res_valid,
    output logic [HOP_W-1:0]  res_hop,
    output logic              res_miss
);
    // Load decode
    logic we_l1, we_l2;
    assign we_l1 = ld_en && (level_e'(ld_level) == LVL_FIRST);
    assign we_l2 = ld_en && (level_e'(ld_level) == LVL_SECOND);

    // Stage 1: first-table read
    logic [ENTRY_W-1:0] l1_rd;
    logic               s1_valid;
    logic [LOW_W-1:0]   s1_low;
    l1_entry_t          s1_ent;

    rlk_table #(.AW(L1_IDX_W), .DW(ENTRY_W)) u_l1 (
        .clk   (clk),
        .we    (we_l1),
        .waddr (ld_addr[L1_IDX_W-1:0]),
        .wdata (ld_data),
        .raddr (lk_addr[ADDR_W-1:LOW_W]),
        .rdata (l1_rd)
    );

    assign s1_ent = l1_entry_t'(l1_rd);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_low   <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_low   <= lk_addr[LOW_W-1:0];
        end
    end

    // Stage 2: second-table read, first-table word carried alongside
    logic [L2_AW-1:0] l2_idx;
    hop_t             l2_rd;
    logic             s2_valid;
    l1_entry_t        s2_ent;

    rlk_l2_index #(.LOW_W(LOW_W), .L2_AW(L2_AW)) u_idx (
        .base (s1_ent.val[L2_AW-1:0]),
        .low  (s1_low),
        .idx  (l2_idx)
    );

    rlk_table #(.AW(L2_AW), .DW(HOP_W)) u_l2 (
        .clk   (clk),
        .we    (we_l2),
        .waddr (ld_addr[L2_AW-1:0]),
        .wdata (ld_data[HOP_W-1:0]),
        .raddr (l2_idx),
        .rdata (l2_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            s2_ent   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_ent   <= s1_ent;
        end
    end

    rlk_resolve u_res (
        .valid     (s2_valid),
        .ent       (s2_ent),
        .l2_word   (l2_rd),
        .out_valid (res_valid),
        .out_hop   (res_hop),
        .out_miss  (res_miss)
    );
endmodule

// File: rtl/route_lookup_chk.sv
module route_lookup_chk
    import rlk_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       lk_valid,
    input logic       res_valid,
    input logic [HOP_W-1:0] res_hop,
    input logic       res_miss
);
    logic v1, v2;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
        end else begin
            v1 <= lk_valid;
            v2 <= v1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        res_valid == v2);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_miss) |-> (res_hop == '0));

    p_hit_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_miss) |-> (res_hop != '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_miss && res_hop == '0));
endmodule

bind route_lookup route_lookup_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_hop   (res_hop),
    .res_miss  (res_miss)
);

// File: tb/tb_route_lookup.sv
module tb_route_lookup;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [19:0] lk_addr;
    logic        ld_en;
    logic        ld_level;
    logic [11:0] ld_addr;
    logic [15:0] ld_data;
    logic        res_valid;
    logic [14:0] res_hop;
    logic        res_miss;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    route_lookup dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .ld_en(ld_en), .ld_level(ld_level), .ld_addr(ld_addr), .ld_data(ld_data),
        .res_valid(res_valid), .res_hop(res_hop), .res_miss(res_miss)
    );

    // {address, expected miss, expected hop}
    localparam logic [35:0] VEC [NV] = '{
        {20'h00105, 1'b0, 15'h0123},   // R3 leaf
        {20'h001FF, 1'b0, 15'h0123},   // R3 low bits ignored
        {20'h00202, 1'b1, 15'h0000},   // R5 empty entry, decoy in L2
        {20'h00300, 1'b0, 15'h0011},   // R4 pointer
        {20'h00305, 1'b0, 15'h0A05},   // R4
        {20'h003FF, 1'b0, 15'h01FF},   // R4 last word of block
        {20'h00306, 1'b1, 15'h0000},   // R6 zero hop from L2
        {20'h00477, 1'b1, 15'h0000},   // R6 zero hop leaf
        {20'h00520, 1'b0, 15'h0777},   // R10 index wrap
        {20'hFFF00, 1'b0, 15'h7FFF}    // R3 top index
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic lvl, input logic [11:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_level = lvl; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; lk_valid = 1'b0; lk_addr = '0;
        ld_en = 1'b0; ld_level = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", res_valid, 0);
        chk("R9 reset hop", res_hop, 0);
        chk("R9 reset miss", res_miss, 0);

        // R7 table loads
        load(1'b0, 12'h001, 16'h8123);
        load(1'b0, 12'h002, 16'h0000);
        load(1'b0, 12'h003, 16'h0100);
        load(1'b0, 12'h004, 16'h8000);
        load(1'b0, 12'h005, 16'h07F0);
        load(1'b0, 12'hFFF, 16'hFFFF);
        load(1'b1, 12'h002, 16'h0555);
        load(1'b1, 12'h100, 16'h0011);
        load(1'b1, 12'h105, 16'h0A05);
        load(1'b1, 12'h106, 16'h0000);
        load(1'b1, 12'h1FF, 16'h01FF);
        load(1'b1, 12'h010, 16'h0777);

        // R2 back-to-back stream, results checked two cycles later
        for (int i = 0; i < NV + 2; i++) begin
            if (i < NV) begin
                lk_valid = 1'b1;
                lk_addr  = VEC[i][35:16];
            end else begin
                lk_valid = 1'b0;
            end
            if (i >= 2) begin
                chk($sformatf("R2 valid vec%0d", i-2), res_valid, 1);
                chk($sformatf("R3/R4/R5/R6/R10 hop vec%0d", i-2), res_hop, VEC[i-2][14:0]);
                chk($sformatf("R6 miss vec%0d", i-2), res_miss, VEC[i-2][15]);
            end
            @(negedge clk);
        end
        chk("R9 idle valid", res_valid, 0);
        chk("R9 idle hop", res_hop, 0);
        chk("R9 idle miss", res_miss, 0);

        // R8 write and lookup of same first-table word in one cycle
        lk_valid = 1'b1; lk_addr = 20'h00105;
        ld_en = 1'b1; ld_level = 1'b0; ld_addr = 12'h001; ld_data = 16'h8456;
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R8 old value", res_hop, 15'h0123);
        @(negedge clk);
        chk("R8 new value", res_hop, 15'h0456);

        // R2 isolated lookup timing
        lk_valid = 1'b1; lk_addr = 20'hFFF00;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R2 not after one edge", res_valid, 0);
        @(negedge clk);
        chk("R2 valid after two edges", res_valid, 1);
        chk("R2 hop after two edges", res_hop, 15'h7FFF);
        @(negedge clk);
        chk("R2 single result", res_valid, 0);

        // R7 second-table update seen by next lookup
        load(1'b1, 12'h105, 16'h0B0B);
        lk_valid = 1'b1; lk_addr = 20'h00305;
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        chk("R7 L2 update", res_hop, 15'h0B0B);

        // R1 reset with lookups in flight
        lk_valid = 1'b1; lk_addr = 20'h00105;
        @(negedge clk);
        rst = 1'b1; lk_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 in-flight discarded", res_valid, 0);
        @(negedge clk);
        chk("R1 stays idle", res_valid, 0);

        done = 1;
        finish_run();
    end
endmodule